// File: doc/BRIEF.md
# String Move, Compare and Skip Engine

This block walks a memory-resident string one element at a time and performs one of three operations on it. A move copies elements from a source area to a destination area. A compare reads both areas side by side and stops at the first pair that differs. A skip reads only the source and advances past elements. Elements are bytes, 16-bit words or 32-bit doublewords. The block reaches memory through a single request/acknowledge port with byte addressing, and elements are carried little-endian in the low lanes of the data bus.

All progress is held in five architectural values. The first is the remaining element count. The second and third are the source and destination pointers. The fourth is the base of a 256-entry byte translation table. The fifth is a match value. The count and both pointers are committed after every element. If an interrupt request stops the engine between two elements, a later start with the committed values fed back finishes the operation as if it had never been stopped. An option nibble selects the stepping direction, byte translation, and an early stop when an element does or does not equal the match value. The result flag tells a count-exhausted finish (0) from a match stop (1).

Top module: `strx_engine`

## Requirements
- R1: While reset is held and after it is released, `busy`, `done`, `mem_req` and `flag_f` are all 0.
- R2: A move with `op_in`=0 copies `cnt_in` elements from `src_in` to `dst_in`. The count drops by exactly 1 per element. Both pointers step by 1, 2 or 4 bytes for `size_in` = 0 (byte), 1 (word) or 2 (doubleword), and memory is read and written little-endian.
- R3: With option bit 1 set, both pointers step downward by the element size instead of upward.
- R4: With option bit 0 set and byte size, each source byte v is replaced by the byte at address `tbl_in`+v before it is matched, compared or stored. For word and doubleword sizes, option bit 0 has no effect.
- R5: With option bit 2 set, the operation stops at the first element, after any translation, that equals the match value when option bit 3 is 1, or that differs from it when option bit 3 is 0. Only the low element-size bits of `val_in` take part. On such a stop `flag_f` becomes 1, that element is not written, and the count and pointers still address it.
- R6: When the count reaches zero the engine stops with `flag_f`=0 and raises `done` for one cycle while `busy` falls.
- R7: A compare with `op_in`=1 reads one element from each pointer and never writes. It stops with `flag_f`=0 at the first unequal pair, with the count and pointers left on that pair.
- R8: A skip with `op_in`=2 reads only the source, never writes, and leaves the destination pointer unchanged. The count that remains is the number of elements not skipped.
- R9: A start with a zero count finishes with `done` in the next cycle and `flag_f`=0, and makes no memory request.
- R10: `int_req` is sampled only after an element's count and pointers are committed. If it is high and the count is not zero, `busy` falls without `done`. A start with the committed values fed back completes the same result as an uninterrupted run.
- R11: Once raised, `mem_req` stays high with a stable `mem_addr` until `mem_ack` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Load the operand inputs and begin (ignored while busy) |
| op_in | input | 2 | 0 move, 1 compare, 2 skip |
| size_in | input | 2 | 0 byte, 1 word, 2 doubleword |
| opts_in | input | 4 | bit3 stop on equal, bit2 match stop enable, bit1 backward, bit0 translate |
| cnt_in | input | AW | Element count to load |
| src_in | input | AW | Source pointer to load |
| dst_in | input | AW | Destination pointer to load |
| tbl_in | input | AW | Translation table base |
| val_in | input | DW | Match value |
| int_req | input | 1 | Request to stop at the next element boundary |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse on a completed operation |
| flag_f | output | 1 | 1 after a match stop, 0 after count exhaustion or compare mismatch |
| cnt_q | output | AW | Committed remaining count |
| src_q | output | AW | Committed source pointer |
| dst_q | output | AW | Committed destination pointer |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_size | output | 2 | Access size, same coding as size_in |
| mem_addr | output | AW | Byte address |
| mem_wdata | output | DW | Write data in the low lanes |
| mem_rdata | input | DW | Read data in the low lanes, valid with mem_ack |
| mem_ack | input | 1 | Request completed |

## Verification
The bench builds the engine with a 10-bit address and a 32-bit data path. A 1 KiB memory then covers the whole address space, so every byte can be compared against a reference copy after each operation, and a write to a wrong address cannot go unseen. The table base sits in the top quarter of that space, so translated lookups, backward runs and word-size masking of the match value all stay in range.

// File: rtl/strx_pkg.sv
package strx_pkg;
  typedef enum logic [1:0] {
    OP_MOVE = 2'd0,
    OP_CMP  = 2'd1,
    OP_SKIP = 2'd2
  } strx_op_e;

  typedef enum logic [2:0] {
    S_IDLE, S_SRC, S_TBL, S_EVAL, S_DST, S_WR, S_STEP
  } strx_state_e;

  // option nibble bit positions
  localparam int OPT_XLATE  = 0;
  localparam int OPT_BACK   = 1;
  localparam int OPT_STOPEN = 2;
  localparam int OPT_ONEQ   = 3;
endpackage

// File: rtl/strx_step.sv
module strx_step #(
  parameter int AW = 32
) (
  input  logic [AW-1:0] ptr,
  input  logic [1:0]    size,
  input  logic          back,
  output logic [AW-1:0] nxt
);
  logic [AW-1:0] stride;

  always_comb begin
    case (size)
      2'd0:    stride = AW'(1);
      2'd1:    stride = AW'(2);
      default: stride = AW'(4);
    endcase
    nxt = back ? (ptr - stride) : (ptr + stride);
  end
endmodule

// File: rtl/strx_eval.sv
module strx_eval #(
  parameter int DW = 32
) (
  input  logic [DW-1:0] elem,
  input  logic [DW-1:0] ref_val,
  input  logic [DW-1:0] dst_val,
  input  logic [DW-1:0] mask,
  input  logic          stop_en,
  input  logic          stop_on_eq,
  output logic          hit,
  output logic          differ
);
  logic eq_ref;

  always_comb begin
    eq_ref = (elem & mask) == (ref_val & mask);
    hit    = stop_en && (stop_on_eq ? eq_ref : !eq_ref);
    differ = (elem & mask) != (dst_val & mask);
  end
endmodule

// File: rtl/strx_engine.sv
module strx_engine
  import strx_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [1:0]    op_in,
  input  logic [1:0]    size_in,
  input  logic [3:0]    opts_in,
  input  logic [AW-1:0] cnt_in,
  input  logic [AW-1:0] src_in,
  input  logic [AW-1:0] dst_in,
  input  logic [AW-1:0] tbl_in,
  input  logic [DW-1:0] val_in,
  input  logic          int_req,
  output logic          busy,
  output logic          done,
  output logic          flag_f,
  output logic [AW-1:0] cnt_q,
  output logic [AW-1:0] src_q,
  output logic [AW-1:0] dst_q,
  output logic          mem_req,
  output logic          mem_we,
  output logic [1:0]    mem_size,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_ack
);
  localparam logic [AW-1:0] CNT_ONE = AW'(1);

  function automatic logic [DW-1:0] lane_mask(input logic [1:0] s);
    case (s)
      2'd0:    return DW'(8'hFF);
      2'd1:    return DW'(16'hFFFF);
      default: return '1;
    endcase
  endfunction

  strx_state_e   state;
  strx_op_e      op_q;
  logic [1:0]    size_q;
  logic [3:0]    opt_q;
  logic [AW-1:0] tbl_q;
  logic [DW-1:0] val_q;
  logic [DW-1:0] elem_q;
  logic          flag_q;
  logic          done_q;

  logic [AW-1:0] src_nx, dst_nx;
  logic          match_stop, dst_differ, xlate_on;
  logic [DW-1:0] rd_mask;

  assign xlate_on = opt_q[OPT_XLATE] && (size_q == 2'd0);

  // memory port, decoded from registered state and pointers
  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = src_q;
    mem_size  = size_q;
    mem_wdata = elem_q;
    case (state)
      S_SRC: mem_req = 1'b1;
      S_TBL: begin
        mem_req  = 1'b1;
        mem_size = 2'd0;
        mem_addr = tbl_q + AW'(elem_q[7:0]);
      end
      S_DST: begin
        mem_req  = 1'b1;
        mem_addr = dst_q;
      end
      S_WR: begin
        mem_req  = 1'b1;
        mem_we   = 1'b1;
        mem_addr = dst_q;
      end
      default: ;
    endcase
  end

  assign rd_mask = lane_mask(mem_size);

  strx_step #(.AW(AW)) u_src_step (
    .ptr(src_q), .size(size_q), .back(opt_q[OPT_BACK]), .nxt(src_nx)
  );
  strx_step #(.AW(AW)) u_dst_step (
    .ptr(dst_q), .size(size_q), .back(opt_q[OPT_BACK]), .nxt(dst_nx)
  );
  strx_eval #(.DW(DW)) u_eval (
    .elem(elem_q), .ref_val(val_q), .dst_val(mem_rdata),
    .mask(lane_mask(size_q)), .stop_en(opt_q[OPT_STOPEN]),
    .stop_on_eq(opt_q[OPT_ONEQ]), .hit(match_stop), .differ(dst_differ)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= S_IDLE;
      op_q   <= OP_MOVE;
      size_q <= 2'd0;
      opt_q  <= 4'd0;
      cnt_q  <= '0;
      src_q  <= '0;
      dst_q  <= '0;
      tbl_q  <= '0;
      val_q  <= '0;
      elem_q <= '0;
      flag_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          op_q   <= strx_op_e'(op_in);
          size_q <= size_in;
          opt_q  <= opts_in;
          cnt_q  <= cnt_in;
          src_q  <= src_in;
          dst_q  <= dst_in;
          tbl_q  <= tbl_in;
          val_q  <= val_in;
          if (cnt_in == '0) begin
            flag_q <= 1'b0;
            done_q <= 1'b1;
          end else begin
            state <= S_SRC;
          end
        end
        S_SRC: if (mem_ack) begin
          elem_q <= mem_rdata & rd_mask;
          state  <= xlate_on ? S_TBL : S_EVAL;
        end
        S_TBL: if (mem_ack) begin
          elem_q <= mem_rdata & rd_mask;
          state  <= S_EVAL;
        end
        S_EVAL: begin
          if (match_stop) begin
            flag_q <= 1'b1;
            done_q <= 1'b1;
            state  <= S_IDLE;
          end else begin
            case (op_q)
              OP_MOVE: state <= S_WR;
              OP_CMP:  state <= S_DST;
              default: state <= S_STEP;
            endcase
          end
        end
        S_DST: if (mem_ack) begin
          if (dst_differ) begin
            flag_q <= 1'b0;
            done_q <= 1'b1;
            state  <= S_IDLE;
          end else begin
            state <= S_STEP;
          end
        end
        S_WR: if (mem_ack) state <= S_STEP;
        S_STEP: begin
          cnt_q <= cnt_q - CNT_ONE;
          src_q <= src_nx;
          if (op_q != OP_SKIP) dst_q <= dst_nx;
          if (cnt_q == CNT_ONE) begin
            flag_q <= 1'b0;
            done_q <= 1'b1;
            state  <= S_IDLE;
          end else if (int_req) begin
            flag_q <= 1'b0;
            state  <= S_IDLE;
          end else begin
            state <= S_SRC;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy   = (state != S_IDLE);
  assign done   = done_q;
  assign flag_f = flag_q;

  // R11
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

  // R2
  cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy) && (cnt_q != $past(cnt_q))) |-> (cnt_q == $past(cnt_q) - CNT_ONE));

  // R7
  no_write_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && (op_q != OP_MOVE)) |-> !mem_we);

  // R9
  zero_cnt_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && start && (cnt_in == '0)) |=> (done && !busy && !mem_req));

  // R10
  int_stop_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(busy) && !done) |-> ($past(int_req) && (cnt_q != '0)));

  // R6
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && !mem_req));
endmodule

// File: tb/strx_engine_tb_top.sv
module strx_engine_tb_top;
  localparam int AW = 10;
  localparam int DW = 32;
  localparam int MSZ = 1024;
  localparam logic [AW-1:0] TBL = 10'h300;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic          start = 1'b0;
  logic [1:0]    op_in = '0, size_in = '0;
  logic [3:0]    opts_in = '0;
  logic [AW-1:0] cnt_in = '0, src_in = '0, dst_in = '0, tbl_in = TBL;
  logic [DW-1:0] val_in = '0;
  logic          int_req = 1'b0;
  logic          busy, done, flag_f, mem_req, mem_we, mem_ack;
  logic [AW-1:0] cnt_q, src_q, dst_q, mem_addr;
  logic [1:0]    mem_size;
  logic [DW-1:0] mem_wdata, mem_rdata;

  strx_engine #(.AW(AW), .DW(DW)) dut_i (
    .clk(clk), .rst(rst), .start(start), .op_in(op_in), .size_in(size_in),
    .opts_in(opts_in), .cnt_in(cnt_in), .src_in(src_in), .dst_in(dst_in),
    .tbl_in(tbl_in), .val_in(val_in), .int_req(int_req), .busy(busy),
    .done(done), .flag_f(flag_f), .cnt_q(cnt_q), .src_q(src_q), .dst_q(dst_q),
    .mem_req(mem_req), .mem_we(mem_we), .mem_size(mem_size),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_ack(mem_ack)
  );

  function automatic logic [7:0] pat(input int i);
    if (i >= 'h300) return ~8'(i - 'h300);
    return 8'(((i & 63) * 37) + 11);
  endfunction

  // memory model and monitors
  logic [7:0]    dmem [0:MSZ-1];
  logic          init_go = 1'b0;
  logic [AW-1:0] poke_a = '0;
  logic [7:0]    poke_v = '0;
  int            done_cnt = 0, xfer_cnt = 0, hold_viol = 0;
  logic          prev_req = 1'b0, prev_ack = 1'b0;
  logic [AW-1:0] prev_addr = '0;

  always @(posedge clk) begin
    if (init_go) begin
      for (int i = 0; i < MSZ; i++) dmem[i] <= pat(i);
      dmem[poke_a] <= poke_v;
    end
    if (rst) begin
      mem_ack <= 1'b0;
      mem_rdata <= '0;
    end else begin
      mem_ack <= mem_req && !mem_ack;
      if (mem_req && !mem_ack) begin
        for (int b = 0; b < 4; b++) mem_rdata[8*b +: 8] <= dmem[mem_addr + AW'(b)];
        if (mem_we)
          for (int b = 0; b < (1 << (mem_size > 2'd1 ? 2 : mem_size)); b++)
            dmem[mem_addr + AW'(b)] <= mem_wdata[8*b +: 8];
      end
      if (done) done_cnt <= done_cnt + 1;
      if (mem_req && mem_ack) xfer_cnt <= xfer_cnt + 1;
      if (prev_req && !prev_ack && (!mem_req || mem_addr != prev_addr))
        hold_viol <= hold_viol + 1;
    end
    prev_req  <= mem_req;
    prev_ack  <= mem_ack;
    prev_addr <= mem_addr;
  end

  // reference copy and model
  logic [7:0] smem [0:MSZ-1];
  int total = 0, bad = 0;
  bit finished = 0;

  task automatic check(input string rq, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic mem_init(input logic [AW-1:0] pa, input logic [7:0] pv);
    for (int i = 0; i < MSZ; i++) smem[i] = pat(i);
    smem[pa] = pv;
    @(negedge clk);
    poke_a = pa; poke_v = pv; init_go = 1'b1;
    @(negedge clk);
    init_go = 1'b0;
  endtask

  function automatic logic [31:0] srd(input int a, input int n);
    logic [31:0] v = '0;
    for (int b = 0; b < n; b++) v[8*b +: 8] = smem[(a + b) % MSZ];
    return v;
  endfunction

  task automatic model(input int op, input int sz, input logic [3:0] opt,
                       input int c, input int s, input int d, input logic [31:0] mv,
                       output int ec, output int es, output int ed, output int ef);
    int n;
    logic [31:0] msk, v, w;
    n   = 1 << (sz > 1 ? 2 : sz);
    msk = (n == 4) ? 32'hFFFF_FFFF : ((32'h1 << (8 * n)) - 1);
    ec = c; es = s; ed = d; ef = 0;
    while (ec != 0) begin
      v = srd(es, n);
      if (opt[0] && sz == 0) v = {24'h0, smem[(int'(TBL) + int'(v)) % MSZ]};
      if (opt[2] && (opt[3] ? (v == (mv & msk)) : (v != (mv & msk)))) begin
        ef = 1;
        return;
      end
      if (op == 1) begin
        w = srd(ed, n);
        if (w != v) return;
      end
      if (op == 0) for (int b = 0; b < n; b++) smem[(ed + b) % MSZ] = v[8*b +: 8];
      ec = ec - 1;
      es = opt[1] ? (es - n + MSZ) % MSZ : (es + n) % MSZ;
      if (op != 2) ed = opt[1] ? (ed - n + MSZ) % MSZ : (ed + n) % MSZ;
    end
  endtask

  task automatic run_op(input int op, input int sz, input logic [3:0] opt,
                        input int c, input int s, input int d, input logic [31:0] mv);
    int guard = 0;
    op_in = 2'(op); size_in = 2'(sz); opts_in = opt;
    cnt_in = AW'(c); src_in = AW'(s); dst_in = AW'(d); val_in = mv;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (busy && guard < 5000) begin
      @(negedge clk);
      guard++;
    end
    @(negedge clk);
  endtask

  task automatic mem_compare(input string rq);
    int miss = 0;
    for (int i = 0; i < MSZ; i++) if (dmem[i] !== smem[i]) miss++;
    check(rq, miss, 0);
  endtask

  typedef struct packed {
    logic [3:0]  rq;
    logic [1:0]  op;
    logic [1:0]  sz;
    logic [3:0]  opt;
    logic [9:0]  cnt;
    logic [9:0]  src;
    logic [9:0]  dst;
    logic [9:0]  pa;
    logic [7:0]  pv;
    logic [31:0] mv;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [0:NV-1] = '{
    '{4'd2,  2'd0, 2'd0, 4'b0000, 10'd5,  10'h040, 10'h200, 10'h2FF, 8'h00, 32'h0},          // R2 byte
    '{4'd2,  2'd0, 2'd1, 4'b0000, 10'd4,  10'h044, 10'h210, 10'h2FF, 8'h00, 32'h0},          // R2 word
    '{4'd2,  2'd0, 2'd2, 4'b0000, 10'd3,  10'h050, 10'h220, 10'h2FF, 8'h00, 32'h0},          // R2 dword
    '{4'd3,  2'd0, 2'd0, 4'b0010, 10'd6,  10'h06F, 10'h23F, 10'h2FF, 8'h00, 32'h0},          // R3 byte back
    '{4'd3,  2'd0, 2'd2, 4'b0010, 10'd2,  10'h070, 10'h248, 10'h2FF, 8'h00, 32'h0},          // R3 dword back
    '{4'd4,  2'd0, 2'd0, 4'b0001, 10'd5,  10'h090, 10'h250, 10'h2FF, 8'h00, 32'h0},          // R4 translate
    '{4'd4,  2'd0, 2'd1, 4'b0001, 10'd3,  10'h090, 10'h260, 10'h2FF, 8'h00, 32'h0},          // R4 ignored on word
    '{4'd5,  2'd0, 2'd0, 4'b1100, 10'd10, 10'h0A0, 10'h270, 10'h0A3, 8'hEE, 32'hEE},         // R5 until
    '{4'd5,  2'd0, 2'd0, 4'b0100, 10'd6,  10'h0B0, 10'h280, 10'h2FF, 8'h00, 32'hFB},         // R5 while
    '{4'd5,  2'd0, 2'd0, 4'b1101, 10'd6,  10'h0C0, 10'h290, 10'h0C2, 8'h11, 32'hEE},         // R5 translated until
    '{4'd7,  2'd1, 2'd0, 4'b0000, 10'd8,  10'h040, 10'h080, 10'h2FF, 8'h00, 32'h0},          // R7 equal
    '{4'd7,  2'd1, 2'd1, 4'b0000, 10'd6,  10'h040, 10'h080, 10'h085, 8'h00, 32'h0},          // R7 mismatch
    '{4'd8,  2'd2, 2'd0, 4'b1100, 10'd12, 10'h0D0, 10'h2A0, 10'h0D4, 8'hEE, 32'hEE},         // R8 skip until
    '{4'd8,  2'd2, 2'd1, 4'b0010, 10'd4,  10'h0F0, 10'h2B0, 10'h2FF, 8'h00, 32'h0},          // R8 skip count
    '{4'd5,  2'd0, 2'd1, 4'b1100, 10'd5,  10'h100, 10'h2C0, 10'h104, 8'h34, 32'hABCD_C434}   // R5 masked word
  };

  initial begin
    int ec, es, ed, ef, d0, x0;
    string rq;
    repeat (3) @(negedge clk);
    // R1 during reset
    check("R1", busy, 0);
    check("R1", mem_req, 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1", done, 0);
    check("R1", flag_f, 0);

    foreach (VECS[k]) begin
      rq = $sformatf("R%0d", VECS[k].rq);
      mem_init(AW'(VECS[k].pa), VECS[k].pv);
      model(VECS[k].op, VECS[k].sz, VECS[k].opt, VECS[k].cnt, VECS[k].src,
            VECS[k].dst, VECS[k].mv, ec, es, ed, ef);
      d0 = done_cnt;
      run_op(VECS[k].op, VECS[k].sz, VECS[k].opt, VECS[k].cnt, VECS[k].src,
             VECS[k].dst, VECS[k].mv);
      check(rq, cnt_q, ec);
      check(rq, src_q, es);
      check(rq, dst_q, ed);
      check(rq, flag_f, ef);
      check("R6", done_cnt - d0, 1);
      mem_compare(rq);
    end

    // R9: zero count after a match stop left the flag at 1
    check("R9", flag_f, 1);
    d0 = done_cnt; x0 = xfer_cnt;
    run_op(0, 0, 4'b0000, 0, 'h040, 'h200, 32'h0);
    check("R9", done_cnt - d0, 1);
    check("R9", xfer_cnt - x0, 0);
    check("R9", flag_f, 0);

    // R10: interrupt after the first element, then resume
    mem_init(10'h2FF, 8'h00);
    model(0, 0, 4'b0000, 6, 'h060, 'h1E0, 32'h0, ec, es, ed, ef);
    int_req = 1'b1;
    d0 = done_cnt;
    run_op(0, 0, 4'b0000, 6, 'h060, 'h1E0, 32'h0);
    check("R10", busy, 0);
    check("R10", done_cnt - d0, 0);
    check("R10", cnt_q, 5);
    check("R10", src_q, 'h061);
    check("R10", dst_q, 'h1E1);
    int_req = 1'b0;
    run_op(0, 0, 4'b0000, int'(cnt_q), int'(src_q), int'(dst_q), 32'h0);
    check("R10", cnt_q, ec);
    check("R10", src_q, es);
    check("R10", dst_q, ed);
    check("R10", done_cnt - d0, 1);
    mem_compare("R10");

    // R11: request held until acknowledged across every run
    check("R11", hold_viol, 0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule